// File: doc/BRIEF.md
# Sprite Attribute Block Copier

This block moves a fixed run of 160 bytes from any 256-byte page of the system address space into the sprite attribute window, which starts at 0xFE00. Software starts a copy by writing a page number to the start register at 0xFF46. The engine then takes the page number as the upper byte of the source address. It waits a fixed number of cycles, then acts as a bus master. For each byte it performs one read from the source page and one write to the matching offset in the attribute window.

The engine asks for the bus with a request output and moves on only in cycles where the grant input is high. Arbitration is left to the system. Reading the start register returns the last page number written. A busy output tells the rest of the chip when a copy is in flight. If a new start write lands during a copy, the old copy is dropped and a new one begins from offset zero.

The controller has four states: IDLE, WAIT (start delay), FETCH (read phase) and STORE (write phase). Transitions:
- KICK: any state to WAIT on a start write.
- DELAY_DONE: WAIT to FETCH when the delay counter reaches zero.
- FETCH_OK: FETCH to STORE when the read is granted.
- STORE_NEXT: STORE to FETCH when a write other than the last is granted.
- STORE_LAST: STORE to IDLE when the last write is granted.

Top module: `spr_attr_dma`

## Requirements
- R1: A register write with `cfg_addr` equal to 0xFF46 and data V starts a copy whose source base is V multiplied by 256. A write to any other address is ignored: busy stays low and the readback value does not change.
- R2: Each copy makes exactly 160 granted writes. Write number i (i = 0 to 159) goes to 0xFE00+i and carries the byte read from source base + i.
- R3: Busy is high in the cycle after the start write. The first bus request appears in busy cycle START_DELAY+1 (the default START_DELAY is 2), so cycles 1 to START_DELAY are the delay.
- R4: Busy falls in the cycle after the last granted write. That write is the final busy cycle.
- R5: `cfg_rdata` returns the last page number written to the start register. It is 0 after reset.
- R6: Each byte uses one granted read (`bus_req` high, `bus_wr` low) followed by one write (`bus_req` and `bus_wr` both high). Reads and writes alternate strictly.
- R7: A start write during an active copy restarts the copy from offset 0 with the new page, including the start delay.
- R8: While `bus_gnt` is low the engine holds its address and strobe and does not advance. A copy therefore takes exactly 320 granted request cycles.
- R9: After reset the engine is idle: `busy`, `bus_req` and `bus_wr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_addr | input | 16 | Register port address |
| cfg_wr | input | 1 | Register port write strobe |
| cfg_wdata | input | 8 | Register port write data (page number) |
| cfg_rdata | output | 8 | Last page number written |
| bus_gnt | input | 1 | Bus grant; the engine advances only when high |
| bus_req | output | 1 | Engine wants the bus this cycle |
| bus_addr | output | 16 | Master address |
| bus_rdata | input | 8 | Read data, valid in the requesting cycle |
| bus_wdata | output | 8 | Write data |
| bus_wr | output | 1 | Write strobe (read when low with `bus_req` high) |
| busy | output | 1 | Copy in progress |

## Verification
The offset register feeds both the source and the destination address, so an offset error shows on the very next granted write as a wrong address or a wrong byte. The bench compares every write against its own image of the memory. A bad state transition or a bad delay count shows at the ports as a shifted first request, a wrong number of granted request cycles, or busy falling before the 160th write. These errors appear within one copy, a few hundred cycles at most. Stalled grants and restarts in mid-copy check that the offset moves only on grant and goes back to zero on a new start.

// File: rtl/spr_dma_pkg.sv
package spr_dma_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_FETCH = 2'd2,
        ST_STORE = 2'd3
    } dma_state_e;

endpackage

// File: rtl/spr_dma_regs.sv
module spr_dma_regs #(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter logic [ADDR_W-1:0] START_ADDR = 16'hFF46
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              cfg_wr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] page_q,
    output logic              kick
);

    // start pulse: a write that hits the start register
    assign kick = cfg_wr && (cfg_addr == START_ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q <= '0;
        end else if (kick) begin
            page_q <= cfg_wdata;
        end
    end

endmodule

// File: rtl/spr_dma_seq.sv
module spr_dma_seq
    import spr_dma_pkg::*;
#(
    parameter int XFER_LEN    = 160,
    parameter int START_DELAY = 2,
    localparam int OFF_W      = $clog2(XFER_LEN),
    localparam int DLY_W      = (START_DELAY > 1) ? $clog2(START_DELAY) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             kick,
    input  logic             bus_gnt,
    output logic [OFF_W-1:0] offset,
    output logic             capture,
    output logic             bus_req,
    output logic             bus_wr,
    output logic             busy
);

    localparam logic [OFF_W-1:0] LAST_OFF  = OFF_W'(XFER_LEN - 1);
    localparam logic [DLY_W-1:0] DLY_LOAD  = DLY_W'(START_DELAY - 1);

    dma_state_e       state_q, state_d;
    logic [DLY_W-1:0] dly_q;
    logic [OFF_W-1:0] off_q;
    logic             last_byte;

    assign last_byte = (off_q == LAST_OFF);

    // next-state logic; transition names follow the brief
    always_comb begin
        state_d = state_q;
        if (kick) begin
            state_d = ST_WAIT;                              // KICK
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_WAIT:  if (dly_q == '0) state_d = ST_FETCH;  // DELAY_DONE
                ST_FETCH: if (bus_gnt) state_d = ST_STORE;      // FETCH_OK
                ST_STORE: begin
                    if (bus_gnt) begin
                        state_d = last_byte ? ST_IDLE           // STORE_LAST
                                            : ST_FETCH;         // STORE_NEXT
                    end
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // delay counter and byte offset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dly_q <= '0;
            off_q <= '0;
        end else if (kick) begin
            dly_q <= DLY_LOAD;
            off_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE:  off_q <= '0;
                ST_WAIT:  if (dly_q != '0) dly_q <= dly_q - 1'b1;
                ST_FETCH: ;
                ST_STORE: if (bus_gnt && !last_byte) off_q <= off_q + 1'b1;
            endcase
        end
    end

    // outputs
    always_comb begin
        bus_req = 1'b0;
        bus_wr  = 1'b0;
        busy    = 1'b0;
        capture = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_WAIT:  busy = 1'b1;
            ST_FETCH: begin
                busy    = 1'b1;
                bus_req = 1'b1;
                capture = bus_gnt;
            end
            ST_STORE: begin
                busy    = 1'b1;
                bus_req = 1'b1;
                bus_wr  = 1'b1;
            end
        endcase
    end

    assign offset = off_q;

endmodule

// File: rtl/spr_dma_path.sv
module spr_dma_path #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int OFF_W  = 8,
    parameter logic [ADDR_W-1:0] DST_BASE = 16'hFE00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] page,
    input  logic [OFF_W-1:0]  offset,
    input  logic              capture,
    input  logic              store_phase,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata
);

    localparam int SHIFT = ADDR_W - DATA_W;

    logic [ADDR_W-1:0] src_base;
    logic [ADDR_W-1:0] off_ext;
    logic [DATA_W-1:0] data_q;

    assign src_base = {page, {SHIFT{1'b0}}};
    assign off_ext  = {{(ADDR_W-OFF_W){1'b0}}, offset};

    always_comb begin
        if (store_phase) begin
            bus_addr = DST_BASE + off_ext;
        end else begin
            bus_addr = src_base + off_ext;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (capture) begin
            data_q <= bus_rdata;
        end
    end

    assign bus_wdata = data_q;

endmodule

// File: rtl/spr_attr_dma.sv
module spr_attr_dma #(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 8,
    parameter int XFER_LEN    = 160,
    parameter int START_DELAY = 2,
    parameter logic [ADDR_W-1:0] START_ADDR = 16'hFF46,
    parameter logic [ADDR_W-1:0] DST_BASE   = 16'hFE00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              cfg_wr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              bus_gnt,
    output logic              bus_req,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_wr,
    output logic              busy
);

    localparam int OFF_W = $clog2(XFER_LEN);

    logic [DATA_W-1:0] page_q;
    logic              kick;
    logic [OFF_W-1:0]  offset;
    logic              capture;

    spr_dma_regs #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .START_ADDR (START_ADDR)
    ) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_addr  (cfg_addr),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .page_q    (page_q),
        .kick      (kick)
    );

    spr_dma_seq #(
        .XFER_LEN    (XFER_LEN),
        .START_DELAY (START_DELAY)
    ) seq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .kick    (kick),
        .bus_gnt (bus_gnt),
        .offset  (offset),
        .capture (capture),
        .bus_req (bus_req),
        .bus_wr  (bus_wr),
        .busy    (busy)
    );

    spr_dma_path #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .OFF_W    (OFF_W),
        .DST_BASE (DST_BASE)
    ) path_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .page        (page_q),
        .offset      (offset),
        .capture     (capture),
        .store_phase (bus_wr),
        .bus_rdata   (bus_rdata),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata)
    );

    assign cfg_rdata = page_q;

endmodule

// File: rtl/spr_attr_dma_chk.sv
module spr_attr_dma_chk #(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 8,
    parameter int XFER_LEN = 160,
    parameter logic [ADDR_W-1:0] START_ADDR = 16'hFF46,
    parameter logic [ADDR_W-1:0] DST_BASE   = 16'hFE00
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] cfg_addr,
    input logic              cfg_wr,
    input logic [DATA_W-1:0] cfg_wdata,
    input logic [DATA_W-1:0] cfg_rdata,
    input logic              bus_gnt,
    input logic              bus_req,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              busy
);

    logic       start_hit;
    logic [15:0] wr_cnt;

    assign start_hit = cfg_wr && (cfg_addr == START_ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_cnt <= '0;
        end else if (start_hit) begin
            wr_cnt <= '0;
        end else if (bus_wr && bus_gnt) begin
            wr_cnt <= wr_cnt + 1'b1;
        end
    end

    // R2: writes stay inside the attribute window
    p_dst_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> ((32'(bus_addr) >= 32'(DST_BASE)) &&
                    (32'(bus_addr) <  32'(DST_BASE) + XFER_LEN)));

    // R3: a start write raises busy next cycle
    p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start_hit |=> busy);

    // R3: the first busy cycle is a delay cycle
    p_delay_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !bus_req);

    // R4: busy only falls after the full count of writes
    p_full_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (wr_cnt == 16'(XFER_LEN)));

    // R5: readback follows the last start write
    p_readback_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start_hit |=> (cfg_rdata == $past(cfg_wdata)));

    // R6: a granted read is followed by a write
    p_read_then_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_wr && bus_gnt && !start_hit) |=> bus_wr);

    // R6: a granted write is never followed directly by another write
    p_write_then_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_gnt && !start_hit) |=> !bus_wr);

    // R8: no grant means no movement
    p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt && !start_hit) |=>
            ($stable(bus_addr) && $stable(bus_wr) && bus_req));

    // R9: idle engine stays off the bus
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!bus_req && !bus_wr));

endmodule

bind spr_attr_dma spr_attr_dma_chk #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .XFER_LEN   (XFER_LEN),
    .START_ADDR (START_ADDR),
    .DST_BASE   (DST_BASE)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_addr  (cfg_addr),
    .cfg_wr    (cfg_wr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .bus_gnt   (bus_gnt),
    .bus_req   (bus_req),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .busy      (busy)
);

// File: tb/spr_attr_dma_tb.sv
module spr_attr_dma_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DLY        = 2;
    localparam int LEN        = 160;
    localparam logic [15:0] START_A = 16'hFF46;
    localparam logic [15:0] DST_A   = 16'hFE00;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_addr = '0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic        bus_gnt = 1'b0;
    logic        bus_req;
    logic [15:0] bus_addr;
    logic [7:0]  bus_rdata;
    logic [7:0]  bus_wdata;
    logic        bus_wr;
    logic        busy;

    logic [7:0] mem [0:65535];

    int unsigned n_total = 0;
    int unsigned n_fail  = 0;
    int unsigned cyc     = 0;

    // monitor state
    logic [7:0]  cur_page = '0;
    int unsigned mon_cyc = 0, mon_gnt = 0, mon_wr = 0, mon_bad = 0;
    int unsigned first_req = 0, last_wr_cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign bus_rdata = mem[bus_addr];

    spr_attr_dma #(.START_DELAY(DLY)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_addr  (cfg_addr),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .bus_gnt   (bus_gnt),
        .bus_req   (bus_req),
        .bus_addr  (bus_addr),
        .bus_rdata (bus_rdata),
        .bus_wdata (bus_wdata),
        .bus_wr    (bus_wr),
        .busy      (busy)
    );

    function automatic logic [15:0] src_of(logic [7:0] pg, int unsigned i);
        return {pg, 8'h00} + 16'(i);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // bus monitor, samples after the bench drives at the falling edge
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            if (busy) mon_cyc++;
            if (bus_req && first_req == 0) first_req = mon_cyc;
            if (bus_req && bus_gnt) begin
                mon_gnt++;
                if (bus_wr) begin
                    if (bus_addr !== DST_A + 16'(mon_wr)) mon_bad++;
                    if (bus_wdata !== mem[src_of(cur_page, mon_wr)]) mon_bad++;
                    mon_wr++;
                    if (mon_wr == LEN) last_wr_cyc = mon_cyc;
                end else begin
                    if (bus_addr !== src_of(cur_page, mon_wr)) mon_bad++;
                end
            end
        end
    end

    task automatic start_xfer(logic [7:0] pg);
        @(negedge clk);
        bus_gnt   = 1'b0;
        cfg_addr  = START_A;
        cfg_wdata = pg;
        cfg_wr    = 1'b1;
        @(negedge clk);
        cfg_wr      = 1'b0;
        cur_page    = pg;
        mon_cyc     = 0;
        mon_gnt     = 0;
        mon_wr      = 0;
        mon_bad     = 0;
        first_req   = 0;
        last_wr_cyc = 0;
        check("R3", 32'(busy), 32'd1, "busy after start write");
        check("R5", 32'(cfg_rdata), 32'(pg), "readback of page");
    endtask

    task automatic finish_xfer(int unsigned pct, string tag, logic chk_first);
        int unsigned guard = 0;
        while (busy && guard < 20000) begin
            bus_gnt = ($urandom_range(99) < pct);
            @(negedge clk);
            guard++;
        end
        bus_gnt = 1'b0;
        @(negedge clk);
        check("watchdog", 32'(guard < 20000), 32'd1, "transfer finished");
        check("R2", mon_wr, LEN, {tag, " write count"});
        check("R2", mon_bad, 0, {tag, " address/data mismatches"});
        check("R6", mon_gnt, 2 * LEN, {tag, " granted request cycles"});
        check("R8", mon_cyc - DLY, 2 * LEN + (mon_cyc - DLY - mon_gnt),
              {tag, " no advance without grant"});
        check("R4", mon_cyc, last_wr_cyc, {tag, " busy ends with last write"});
        if (chk_first) check("R3", first_req, DLY + 1, {tag, " first request cycle"});
    endtask

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 190000", cyc);
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 65536; i++) mem[i] = 8'($urandom);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        check("R9", 32'(busy), 32'd0, "busy after reset");
        check("R9", 32'({bus_req, bus_wr}), 32'd0, "bus idle after reset");
        check("R5", 32'(cfg_rdata), 32'd0, "readback after reset");

        // R1: write to a neighbouring address is ignored
        cfg_addr = START_A + 16'd1; cfg_wdata = 8'h5A; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        @(negedge clk);
        check("R1", 32'(busy), 32'd0, "busy after foreign write");
        check("R1", 32'(cfg_rdata), 32'd0, "readback after foreign write");

        // R1 R3 R4: full-grant copy from page 0xC0
        start_xfer(8'hC0);
        finish_xfer(100, "R1 full grant", 1'b1);
        check("R4", mon_cyc, DLY + 2 * LEN, "busy length at full grant");

        // R8: hold grant low after the delay, bus must freeze
        start_xfer(8'h12);
        bus_gnt = 1'b0;
        repeat (DLY + 20) @(negedge clk);
        check("R8", 32'({busy, bus_req, bus_wr}), 32'b110, "stalled in read phase");
        check("R8", 32'(bus_addr), 32'(src_of(8'h12, 0)), "stalled address");
        finish_xfer(100, "R8 after stall", 1'b1);

        // R7: restart in mid-copy with a new page
        start_xfer(8'h40);
        while (mon_wr < 50) begin
            bus_gnt = 1'b1;
            @(negedge clk);
            #2;
        end
        start_xfer(8'h81);
        finish_xfer(100, "R7 restart", 1'b1);
        check("R7", 32'(cfg_rdata), 32'h81, "readback after restart");

        // random pages and grant rates
        for (int t = 0; t < 8; t++) begin
            logic [7:0] pg;
            pg = 8'($urandom);
            start_xfer(pg);
            finish_xfer($urandom_range(90, 25), "R2 random", 1'b0);
        end

        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule